// File: doc/BRIEF.md
# Protection Context Write-Filter Register

This block is one master's control register that keeps the master's current protection context, a 4-bit value, beside a 16-bit permission mask. Each bit of the mask names one context value that software is allowed to move the master into. Every register write carries the context of the agent issuing it. A writer running in context 0 is fully trusted and may load any context. Any other writer can move the context field only to a value whose mask bit was already set before the write. A request that fails this check leaves the context unchanged. The same write still updates every other field.

The register also holds a default privilege bit, a default security bit and a 2-bit arbitration priority. The interconnect uses the two default bits for masters that drive no attribute of their own. A hardware handler-valid vector marks contexts that belong to hardware handlers. While bit i of that vector is high, any write clears mask bit i, whatever the data says, so software cannot re-open a handler's context. A separate hardware-entry strobe loads the context field directly and bypasses the mask.

Access uses a single write strobe and a single read strobe, with no address. The register image is laid out as follows:
- bit 0: privilege default (0 user, 1 privileged)
- bit 1: security default (0 secure, 1 non-secure)
- bits 7:4: context
- bits 9:8: priority
- bits 31:16: mask, with bit 16+i being mask bit i

Top module: `pcx_guard_reg`

## Requirements
- R1: After reset the read image is 0x0000_0303 (privileged, non-secure, priority field all ones, context 0, mask all zero), and `curCtx` is 0.
- R2: A write stores privilege from bit 0, security from bit 1 and priority from bits 9:8. The read image returns them at the same positions, the context at bits 7:4 and the mask at bits 31:16; bits 3:2 and 15:10 read as zero.
- R3: Mask bit 0 (image bit 16) always reads 0, whatever value is written to it.
- R4: When a write comes from a nonzero writer context, the context field takes the requested value v (`wrData[7:4]`) only if mask bit v was 1 before the write. Otherwise the context keeps its old value.
- R5: When a write comes from writer context 0, the context field takes the requested value, any value including 0, regardless of the mask.
- R6: When a write occurs while `hndlValid[i]` is 1, mask bit i is stored as 0 regardless of the written data.
- R7: `hwEnter` loads `hwCtx` into the context field regardless of the mask. When a software write happens in the same cycle, the hardware value wins for the context, and the write's other fields are still stored.
- R8: `rdData` captures the register image on the clock edge where `rdEn` is high, so it is valid one cycle later. It holds its value while `rdEn` is low.
- R9: With neither `wrEn` nor `hwEnter` high, the context and the mask keep their values.
- R10: `curCtx` always shows the stored context field, updating on the same edge as the write or hardware entry that changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Write data image |
| wrCtx | input | 4 | Protection context of the writer |
| hndlValid | input | 16 | Per-context hardware handler valid |
| hwEnter | input | 1 | Hardware context entry strobe |
| hwCtx | input | 4 | Context loaded on hardware entry |
| rdEn | input | 1 | Read strobe |
| rdData | output | 32 | Registered read image |
| curCtx | output | 4 | Current protection context |

## Verification
The bench builds the block with its package defaults: a 4-bit context, a 16-entry mask and a 2-bit priority. With these values every context value and every mask bit can be reached from a 4-bit request field. The vector walk covers these cases:
- accepted and denied context changes from untrusted writers, where the decision depends on the mask as it stood before the same write;
- trusted writes back to context 0;
- handler-forced clears of mask bits.

Directed cases cover a hardware entry colliding with a software write, hardware entry into a context whose mask bit is clear, and read-data holding between read strobes.

// File: rtl/pcx_pkg.sv
package pcx_pkg;
  localparam int CTX_W    = 4;
  localparam int NUM_CTX  = 1 << CTX_W;
  localparam int PRIO_W   = 2;
  localparam int PRIV_BIT = 0;
  localparam int SEC_BIT  = 1;
  localparam int CTX_LSB  = 4;
  localparam int PRIO_LSB = 8;
  localparam int MASK_LSB = 16;
  localparam int DATA_W   = MASK_LSB + NUM_CTX;

  typedef struct packed {
    logic               ldCfg;
    logic               ldCtx;
    logic               ldRead;
    logic [CTX_W-1:0]   ctxNext;
    logic [NUM_CTX-1:0] maskNext;
  } pcxStrobes_t;
endpackage

// File: rtl/pcx_ctrl.sv
module pcx_ctrl
  import pcx_pkg::*;
(
  input  logic               wrEn,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [CTX_W-1:0]   wrCtx,
  input  logic [NUM_CTX-1:0] maskQ,
  input  logic [NUM_CTX-1:0] hndlValid,
  input  logic               hwEnter,
  input  logic [CTX_W-1:0]   hwCtx,
  input  logic               rdEn,
  output pcxStrobes_t        strb
);
  logic [CTX_W-1:0]   reqCtx;
  logic               trustedWriter;
  logic               ctxPermitted;
  logic [NUM_CTX-1:0] filteredMask;
  logic               unusedCtrlBits;

  assign reqCtx         = wrData[CTX_LSB +: CTX_W];
  assign unusedCtrlBits = ^{wrData[CTX_LSB-1:0], wrData[MASK_LSB-1:CTX_LSB+CTX_W], hndlValid[0]};

  // Mask bit 0 is never writable; handler-owned contexts are forced clear.
  assign filteredMask[0] = 1'b0;
  for (genvar i = 1; i < NUM_CTX; i++) begin : g_maskFilter
    assign filteredMask[i] = wrData[MASK_LSB + i] & ~hndlValid[i];
  end

  always_comb begin
    trustedWriter = (wrCtx == '0);
    ctxPermitted  = trustedWriter | maskQ[reqCtx];
    strb.ldCfg    = wrEn;
    strb.ldRead   = rdEn;
    strb.maskNext = filteredMask;
    strb.ldCtx    = hwEnter | (wrEn & ctxPermitted);
    strb.ctxNext  = hwEnter ? hwCtx : reqCtx;
  end
endmodule

// File: rtl/pcx_datapath.sv
module pcx_datapath
  import pcx_pkg::*;
#(
  parameter logic             RESET_PRIV = 1'b1,
  parameter logic             RESET_SEC  = 1'b1,
  parameter logic [PRIO_W-1:0] RESET_PRIO = '1
) (
  input  logic               clk,
  input  logic               rstN,
  input  pcxStrobes_t        strb,
  input  logic [DATA_W-1:0]  wrData,
  output logic [CTX_W-1:0]   ctxQ,
  output logic [NUM_CTX-1:0] maskQ,
  output logic [DATA_W-1:0]  rdData
);
  logic              privQ;
  logic              secQ;
  logic [PRIO_W-1:0] prioQ;
  logic [DATA_W-1:0] image;
  logic              unusedDpBits;

  assign unusedDpBits = ^{wrData[CTX_LSB-1:SEC_BIT+1], wrData[PRIO_LSB-1:CTX_LSB],
                          wrData[MASK_LSB-1:PRIO_LSB+PRIO_W], wrData[DATA_W-1:MASK_LSB]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      privQ <= RESET_PRIV;
      secQ  <= RESET_SEC;
      prioQ <= RESET_PRIO;
      maskQ <= '0;
    end else if (strb.ldCfg) begin
      privQ <= wrData[PRIV_BIT];
      secQ  <= wrData[SEC_BIT];
      prioQ <= wrData[PRIO_LSB +: PRIO_W];
      maskQ <= strb.maskNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           ctxQ <= '0;
    else if (strb.ldCtx) ctxQ <= strb.ctxNext;
  end

  always_comb begin
    image                         = '0;
    image[PRIV_BIT]               = privQ;
    image[SEC_BIT]                = secQ;
    image[CTX_LSB +: CTX_W]       = ctxQ;
    image[PRIO_LSB +: PRIO_W]     = prioQ;
    image[MASK_LSB +: NUM_CTX]    = maskQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdData <= '0;
    else if (strb.ldRead) rdData <= image;
  end
endmodule

// File: rtl/pcx_guard_reg.sv
module pcx_guard_reg
  import pcx_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [CTX_W-1:0]   wrCtx,
  input  logic [NUM_CTX-1:0] hndlValid,
  input  logic               hwEnter,
  input  logic [CTX_W-1:0]   hwCtx,
  input  logic               rdEn,
  output logic [DATA_W-1:0]  rdData,
  output logic [CTX_W-1:0]   curCtx
);
  pcxStrobes_t        strb;
  logic [NUM_CTX-1:0] maskState;

  pcx_ctrl u_ctrl (
    .wrEn      (wrEn),
    .wrData    (wrData),
    .wrCtx     (wrCtx),
    .maskQ     (maskState),
    .hndlValid (hndlValid),
    .hwEnter   (hwEnter),
    .hwCtx     (hwCtx),
    .rdEn      (rdEn),
    .strb      (strb)
  );

  pcx_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (wrData),
    .ctxQ   (curCtx),
    .maskQ  (maskState),
    .rdData (rdData)
  );
endmodule

// File: rtl/pcx_guard_chk.sv
module pcx_guard_chk
  import pcx_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [DATA_W-1:0]  wrData,
  input logic [CTX_W-1:0]   wrCtx,
  input logic [NUM_CTX-1:0] hndlValid,
  input logic               hwEnter,
  input logic [CTX_W-1:0]   hwCtx,
  input logic [CTX_W-1:0]   curCtx,
  input logic [NUM_CTX-1:0] maskState
);
  p_mask0_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    !maskState[0]);

  p_denied_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !hwEnter && wrCtx != '0 && !maskState[wrData[CTX_LSB +: CTX_W]])
      |=> $stable(curCtx));

  p_trusted_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !hwEnter && wrCtx == '0) |=> curCtx == $past(wrData[CTX_LSB +: CTX_W]));

  p_handler_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (maskState & $past(hndlValid)) == '0);

  p_hw_entry_r7: assert property (@(posedge clk) disable iff (!rstN)
    hwEnter |=> curCtx == $past(hwCtx));

  p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !hwEnter) |=> ($stable(curCtx) && $stable(maskState)));
endmodule

bind pcx_guard_reg pcx_guard_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrData    (wrData),
  .wrCtx     (wrCtx),
  .hndlValid (hndlValid),
  .hwEnter   (hwEnter),
  .hwCtx     (hwCtx),
  .curCtx    (curCtx),
  .maskState (maskState)
);

// File: tb/pcx_guard_reg_tb.sv
module pcx_guard_reg_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [3:0]  wrCtx = '0;
  logic [15:0] hndlValid = '0;
  logic        hwEnter = 1'b0;
  logic [3:0]  hwCtx = '0;
  logic        rdEn = 1'b0;
  logic [31:0] rdData;
  logic [3:0]  curCtx;

  int checkCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pcx_guard_reg u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .wrCtx(wrCtx),
    .hndlValid(hndlValid), .hwEnter(hwEnter), .hwCtx(hwCtx), .rdEn(rdEn),
    .rdData(rdData), .curCtx(curCtx)
  );

  // {writer ctx, write data, handler valid, expected image}
  localparam logic [83:0] VEC [8] = '{
    {4'h0, 32'hFFFF_FFFF, 16'h0000, 32'hFFFE_03F3}, // R5 R2 R3 trusted load ctx F
    {4'h2, 32'h0024_0150, 16'h0000, 32'h0024_0150}, // R4 mask bit 5 set: accept ctx 5
    {4'h5, 32'h0024_0231, 16'h0000, 32'h0024_0251}, // R4 mask bit 3 clear: deny
    {4'h5, 32'h0024_0022, 16'h0020, 32'h0004_0022}, // R6 handler 5 clears mask bit 5
    {4'h2, 32'h0025_0353, 16'h0000, 32'h0024_0323}, // R4 deny ctx 5, R3 bit 0 dropped
    {4'h0, 32'h0000_0000, 16'h0000, 32'h0000_0000}, // R5 trusted back to ctx 0
    {4'h0, 32'h0001_0090, 16'h0000, 32'h0000_0090}, // R5 ctx 9, R3 mask 0 stays clear
    {4'h9, 32'hFFFF_0000, 16'h0000, 32'hFFFE_0090}  // R4 deny ctx 0 (old mask empty)
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [3:0] ctx, input logic [31:0] data, input logic [15:0] hv);
    @(negedge clk);
    wrEn = 1'b1; wrCtx = ctx; wrData = data; hndlValid = hv;
    @(negedge clk);
    wrEn = 1'b0; hndlValid = '0;
  endtask

  task automatic doRead();
    @(negedge clk);
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failCnt++;
      checkCnt++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset image and context
    doRead();
    check(rdData, 32'h0000_0303, "R1 reset image");
    check({28'h0, curCtx}, 32'h0, "R1 reset ctx");

    for (int i = 0; i < 8; i++) begin
      doWrite(VEC[i][83:80], VEC[i][79:48], VEC[i][47:32]);
      doRead();
      check(rdData, VEC[i][31:0], $sformatf("R2/R4 vector %0d image", i));
      check({28'h0, curCtx}, {28'h0, VEC[i][7:4]}, $sformatf("R10 vector %0d ctx", i));
    end

    // R8: a write without a read strobe leaves rdData unchanged
    doWrite(4'h0, 32'h0000_0290, 16'h0000);
    repeat (2) @(negedge clk);
    check(rdData, 32'hFFFE_0090, "R8 rdData holds");
    doRead();
    check(rdData, 32'h0000_0290, "R8 rdData updates");

    // R7: hardware entry collides with software write (ctx 4, prio 1)
    @(negedge clk);
    wrEn = 1'b1; wrCtx = 4'h0; wrData = 32'h0000_0140; hwEnter = 1'b1; hwCtx = 4'hC;
    @(negedge clk);
    wrEn = 1'b0; hwEnter = 1'b0;
    doRead();
    check(rdData, 32'h0000_01C0, "R7 hw wins, other fields written");

    // R7: hardware entry bypasses an empty mask
    @(negedge clk);
    hwEnter = 1'b1; hwCtx = 4'h3;
    @(negedge clk);
    hwEnter = 1'b0;
    check({28'h0, curCtx}, 32'h3, "R7 hw entry bypasses mask");

    // R9: idle cycles leave context and mask alone
    repeat (5) @(negedge clk);
    doRead();
    check(rdData, 32'h0000_0130, "R9 idle keeps state");
    check({28'h0, curCtx}, 32'h3, "R9 idle ctx");

    done = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule